// File: doc/BRIEF.md
# Shared Transmit Word FIFO with Two-Channel Interleaving

This block buffers transmit words for up to two output channels. A producer writes 32-bit words through a single write port into an eight-entry queue. Each channel asks for its next word by holding a request line high. The block answers with a grant pulse in the same cycle, and the granted word appears on that channel's data output one clock later. When only one channel is set to take words from the queue, that channel reads the words in order. When both channels are set to take words, the queue hands out words alternately, starting with channel 0. Only the channel whose turn it is can be served, so a faster channel waits for the slower one.

The block keeps live empty and full indications. It also keeps sticky error and gap flags, which are cleared by a write-one mask. A one-cycle clear pulse discards all queued words. An optional repeat mode lets a single consuming channel reuse its previous word when the queue is empty. A programmable fill threshold drives a DMA request, and a second threshold drives a panic indication.

Top module: `txf_shared_fifo`

## Requirements
- R1: After reset the queue is empty (empty=1, full=0). All sticky flags are 0, both channel data outputs are 0, DMA is disabled (dmaReq=0), both thresholds are 7, and therefore dmaPanic=1.
- R2: With exactly one channel enabled for the queue, that channel receives the written words in write order. At most eight words are held, and full=1 exactly when eight words are held.
- R3: A write while full is dropped and sets the sticky wrErr flag.
- R4: With both channels enabled, words are granted alternately, first to channel 0 and then to channel 1. The written sequence A B C D is delivered as A C to channel 0 and B D to channel 1.
- R5: With both channels enabled, a request from the channel whose turn it is not gets no grant and removes no word until the other channel has taken its word.
- R6: With one channel enabled and its repeat bit set, a request on an empty queue is granted and that channel's data output keeps its previous word. No gap or read error is raised.
- R7: Repeat bits have no effect while both channels are enabled: a request on an empty queue is not granted and sets the gap flag of that channel.
- R8: A request from an enabled channel that finds the queue empty, and is not covered by R6, gets no grant. It sets rdErr and the gap flag of that channel only (gap bit 0 is channel 0, bit 1 is channel 1).
- R9: On a flagClrWr strobe, each set bit of flagClrMask clears one flag (bit 0 wrErr, bit 1 rdErr, bit 2 gap[0], bit 3 gap[1]). Mask bits that are 0 leave their flags unchanged. A flag set in the same cycle wins over the clear.
- R10: A clearFifo pulse empties the queue in one cycle. A write or request in that same cycle is dropped, and the turn returns to channel 0.
- R11: A cfgWr strobe loads the DMA enable and the two 8-bit thresholds. dmaReq = enable AND (fill count <= request threshold). dmaPanic = fill count <= panic threshold.
- R12: A request from a channel whose queue-enable bit is 0 is ignored: there is no grant, no word is removed, and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrValid | input | 1 | Write strobe for wrData |
| wrData | input | 32 | Word to enqueue |
| clearFifo | input | 1 | One-cycle pulse that discards all queued words |
| useFifo | input | 2 | Per-channel queue enable |
| repeatLast | input | 2 | Per-channel repeat-on-empty enable |
| chReq | input | 2 | Per-channel request for the next word |
| chGrant | output | 2 | Per-channel grant, in the cycle the request is accepted |
| ch0Data | output | 32 | Word last granted to channel 0 |
| ch1Data | output | 32 | Word last granted to channel 1 |
| empty | output | 1 | Queue holds no words |
| full | output | 1 | Queue holds eight words |
| flagClrWr | input | 1 | Strobe that applies flagClrMask |
| flagClrMask | input | 4 | Write-one-to-clear mask for the sticky flags |
| wrErr | output | 1 | Sticky write-while-full flag |
| rdErr | output | 1 | Sticky read-while-empty flag |
| gap | output | 2 | Sticky per-channel gap flags |
| cfgWr | input | 1 | Strobe that loads the DMA configuration |
| cfgDmaEn | input | 1 | DMA enable value |
| cfgDreqThr | input | 8 | Request threshold value |
| cfgPanicThr | input | 8 | Panic threshold value |
| dmaReq | output | 1 | DMA request |
| dmaPanic | output | 1 | Panic indication |

## Verification
The bench targets the edges of the queue. It writes into a full queue, where a design with an off-by-one full check would accept a ninth word or skip the error. It requests from an empty queue, where a wrong design would hand out stale storage or set the gap flag of the wrong channel. In the shared mode it checks both the alternation and the lock step: a design that served any requester would let channel 1 steal word A. It also checks that clearing restarts the alternation at channel 0, where a design that kept its turn pointer would give the first word after the clear to channel 1. Repeat mode is checked both where it applies and where it must be ignored. The write-one mask is checked for partial clears. A random single-channel phase compares data and levels against a queue model.

// File: rtl/txf_pkg.sv
`timescale 1ns/1ps
package txf_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic       push;
    logic       clear;
    logic [1:0] load;   // pop head into the channel data register
  } txfStrobes_t;
endpackage

// File: rtl/txf_datapath.sv
`timescale 1ns/1ps
module txf_datapath
  import txf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  txfStrobes_t       strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              full,
  output logic [DATA_W-1:0] ch0Data,
  output logic [DATA_W-1:0] ch1Data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic              pop;
  logic [DATA_W-1:0] headWord;

  assign pop      = |strb.load;
  assign headWord = mem[rdPtr];
  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= bump(wrPtr);
      if (pop)       rdPtr <= bump(rdPtr);
      count <= count + CNT_W'(strb.push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ch0Data <= '0;
      ch1Data <= '0;
    end else begin
      if (strb.load[0]) ch0Data <= headWord;
      if (strb.load[1]) ch1Data <= headWord;
    end
  end

  // R2
  // level_bound_chk
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R10
  // clear_empties_chk
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> empty);

  // R2
  // flags_exclusive_chk
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));
endmodule

// File: rtl/txf_ctrl.sv
`timescale 1ns/1ps
module txf_ctrl
  import txf_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int THR_W = 8,
  parameter logic [THR_W-1:0] THR_RST = THR_W'(7)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic             clearFifo,
  input  logic [1:0]       useFifo,
  input  logic [1:0]       repeatLast,
  input  logic [1:0]       chReq,
  input  logic             flagClrWr,
  input  logic [3:0]       flagClrMask,
  input  logic             cfgWr,
  input  logic             cfgDmaEn,
  input  logic [THR_W-1:0] cfgDreqThr,
  input  logic [THR_W-1:0] cfgPanicThr,
  input  logic [CNT_W-1:0] count,
  input  logic             empty,
  input  logic             full,
  output txfStrobes_t      strb,
  output logic [1:0]       chGrant,
  output logic             wrErr,
  output logic             rdErr,
  output logic [1:0]       gap,
  output logic             dmaReq,
  output logic             dmaPanic
);
  logic             shared, single;
  logic             turn;       // 0: channel 0 next, 1: channel 1 next
  logic [1:0]       eligible, take, reuse, starve;
  logic             dmaEn;
  logic [THR_W-1:0] dreqThr, panicThr;
  logic             wrErrSet, rdErrSet;
  logic [3:0]       clrHit;

  assign shared = &useFifo;
  assign single = ^useFifo;

  for (genvar k = 0; k < 2; k++) begin : g_ch
    assign eligible[k] = useFifo[k] && chReq[k] && !clearFifo &&
                         (!shared || (turn == 1'(k)));
    assign take[k]     = eligible[k] && !empty;
    assign reuse[k]    = eligible[k] && empty && single && repeatLast[k];
    assign starve[k]   = eligible[k] && empty && !reuse[k];
  end

  assign chGrant    = take | reuse;
  assign strb.load  = take;
  assign strb.push  = wrValid && !full && !clearFifo;
  assign strb.clear = clearFifo;

  assign wrErrSet = wrValid && full && !clearFifo;
  assign rdErrSet = |starve;
  assign clrHit   = flagClrWr ? flagClrMask : 4'b0000;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      turn <= 1'b0;
    end else if (clearFifo) begin
      turn <= 1'b0;
    end else if (shared && |take) begin
      turn <= ~turn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrErr <= 1'b0;
      rdErr <= 1'b0;
      gap   <= 2'b00;
    end else begin
      wrErr  <= (wrErr  & ~clrHit[0]) | wrErrSet;
      rdErr  <= (rdErr  & ~clrHit[1]) | rdErrSet;
      gap[0] <= (gap[0] & ~clrHit[2]) | starve[0];
      gap[1] <= (gap[1] & ~clrHit[3]) | starve[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaEn    <= 1'b0;
      dreqThr  <= THR_RST;
      panicThr <= THR_RST;
    end else if (cfgWr) begin
      dmaEn    <= cfgDmaEn;
      dreqThr  <= cfgDreqThr;
      panicThr <= cfgPanicThr;
    end
  end

  assign dmaReq   = dmaEn && ({{THR_W{1'b0}}, count} <= {{CNT_W{1'b0}}, dreqThr});
  assign dmaPanic = ({{THR_W{1'b0}}, count} <= {{CNT_W{1'b0}}, panicThr});

  // R5
  // one_grant_chk
  one_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chGrant));

  // R4
  // turn_flip_chk
  turn_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shared && |take && !clearFifo) |=> (turn != $past(turn)));

  // R3
  // full_write_err_chk
  full_write_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && full && !clearFifo) |=> wrErr);

  // R8
  // starve_err_chk
  starve_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|chGrant) |-> !(|starve));

  // R10
  // clear_turn_chk
  clear_turn_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearFifo |=> (turn == 1'b0));
endmodule

// File: rtl/txf_shared_fifo.sv
`timescale 1ns/1ps
module txf_shared_fifo
  import txf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int THR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              clearFifo,
  input  logic [1:0]        useFifo,
  input  logic [1:0]        repeatLast,
  input  logic [1:0]        chReq,
  output logic [1:0]        chGrant,
  output logic [DATA_W-1:0] ch0Data,
  output logic [DATA_W-1:0] ch1Data,
  output logic              empty,
  output logic              full,
  input  logic              flagClrWr,
  input  logic [3:0]        flagClrMask,
  output logic              wrErr,
  output logic              rdErr,
  output logic [1:0]        gap,
  input  logic              cfgWr,
  input  logic              cfgDmaEn,
  input  logic [THR_W-1:0]  cfgDreqThr,
  input  logic [THR_W-1:0]  cfgPanicThr,
  output logic              dmaReq,
  output logic              dmaPanic
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  txfStrobes_t      strb;
  logic [CNT_W-1:0] count;

  txf_ctrl #(.CNT_W(CNT_W), .THR_W(THR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .clearFifo(clearFifo),
    .useFifo(useFifo), .repeatLast(repeatLast), .chReq(chReq),
    .flagClrWr(flagClrWr), .flagClrMask(flagClrMask),
    .cfgWr(cfgWr), .cfgDmaEn(cfgDmaEn), .cfgDreqThr(cfgDreqThr),
    .cfgPanicThr(cfgPanicThr), .count(count), .empty(empty), .full(full),
    .strb(strb), .chGrant(chGrant), .wrErr(wrErr), .rdErr(rdErr),
    .gap(gap), .dmaReq(dmaReq), .dmaPanic(dmaPanic)
  );

  txf_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .count(count), .empty(empty), .full(full),
    .ch0Data(ch0Data), .ch1Data(ch1Data)
  );
endmodule

// File: tb/txf_shared_fifo_bench.sv
`timescale 1ns/1ps
module txf_shared_fifo_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [31:0] wrData = '0;
  logic        clearFifo = 1'b0;
  logic [1:0]  useFifo = 2'b01;
  logic [1:0]  repeatLast = 2'b00;
  logic [1:0]  chReq = 2'b00;
  logic [1:0]  chGrant;
  logic [31:0] ch0Data, ch1Data;
  logic        empty, full;
  logic        flagClrWr = 1'b0;
  logic [3:0]  flagClrMask = 4'b0000;
  logic        wrErr, rdErr;
  logic [1:0]  gap;
  logic        cfgWr = 1'b0;
  logic        cfgDmaEn = 1'b0;
  logic [7:0]  cfgDreqThr = 8'd7;
  logic [7:0]  cfgPanicThr = 8'd7;
  logic        dmaReq, dmaPanic;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  txf_shared_fifo u_txf_shared_fifo (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] expGrant(input int turnIdx);
    return (turnIdx % 2 == 0) ? 2'b01 : 2'b10;
  endfunction

  task automatic nextCycle();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [31:0] w);
    wrValid = 1'b1;
    wrData  = w;
    nextCycle();
    wrValid = 1'b0;
  endtask

  task automatic setCfg(input logic en, input logic [7:0] rq, input logic [7:0] pn);
    cfgWr = 1'b1; cfgDmaEn = en; cfgDreqThr = rq; cfgPanicThr = pn;
    nextCycle();
    cfgWr = 1'b0;
  endtask

  task automatic clrFlags(input logic [3:0] m);
    flagClrWr = 1'b1; flagClrMask = m;
    nextCycle();
    flagClrWr = 1'b0; flagClrMask = 4'b0000;
  endtask

  task automatic doClear();
    clearFifo = 1'b1;
    nextCycle();
    clearFifo = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w [8];
    logic [31:0] s [6];
    logic [31:0] mq [$];
    logic [31:0] lastExp;
    logic [31:0] u;
    void'($urandom(32'd20240611));

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 flags", {wrErr, rdErr, gap}, 0);
    chk("R1 data", ch0Data | ch1Data, 0);
    chk("R1 dmaReq", dmaReq, 0);
    chk("R1 dmaPanic", dmaPanic, 1);
    nextCycle();

    // R11 enable DMA
    setCfg(1'b1, 8'd7, 8'd7);
    @(negedge clk);
    chk("R11 dmaReq at level 0", dmaReq, 1);
    nextCycle();

    // R2 fill single-channel queue
    for (int i = 0; i < 8; i++) begin
      w[i] = $urandom;
      push(w[i]);
    end
    @(negedge clk);
    chk("R2 full after 8", full, 1);
    chk("R2 not empty", empty, 0);
    chk("R11 dmaReq off at 8", dmaReq, 0);
    chk("R11 panic off at 8", dmaPanic, 0);
    nextCycle();

    // R3 write while full
    push(32'hDEAD_BEEF);
    @(negedge clk);
    chk("R3 wrErr", wrErr, 1);
    chk("R3 still full", full, 1);
    nextCycle();

    // R11 raised threshold
    setCfg(1'b1, 8'd8, 8'd8);
    @(negedge clk);
    chk("R11 dmaReq thr 8", dmaReq, 1);
    chk("R11 panic thr 8", dmaPanic, 1);
    nextCycle();
    setCfg(1'b1, 8'd7, 8'd7);

    // R2 drain in order
    for (int i = 0; i < 8; i++) begin
      chReq = 2'b01;
      @(negedge clk);
      chk("R2 grant", chGrant, 2'b01);
      nextCycle();
      chReq = 2'b00;
      @(negedge clk);
      chk("R2 order", ch0Data, w[i]);
      nextCycle();
    end
    @(negedge clk);
    chk("R2 empty after drain", empty, 1);
    chk("R11 panic at 0", dmaPanic, 1);
    nextCycle();

    // R8 request on empty
    chReq = 2'b01;
    @(negedge clk);
    chk("R8 no grant", chGrant, 0);
    nextCycle();
    chReq = 2'b00;
    @(negedge clk);
    chk("R8 gap ch0 only", gap, 2'b01);
    chk("R8 rdErr", rdErr, 1);
    chk("R8 data kept", ch0Data, w[7]);
    nextCycle();

    // R9 write-one-to-clear
    clrFlags(4'b0000);
    @(negedge clk);
    chk("R9 zero mask keeps", {wrErr, rdErr, gap}, 4'b1101);
    nextCycle();
    clrFlags(4'b0101);
    @(negedge clk);
    chk("R9 partial clear", {wrErr, rdErr, gap}, 4'b0100);
    nextCycle();
    clrFlags(4'b0010);
    @(negedge clk);
    chk("R9 rdErr cleared", rdErr, 0);
    nextCycle();

    // R6 repeat last on empty
    repeatLast = 2'b01;
    chReq = 2'b01;
    @(negedge clk);
    chk("R6 repeat grant", chGrant, 2'b01);
    nextCycle();
    chReq = 2'b00;
    @(negedge clk);
    chk("R6 repeated word", ch0Data, w[7]);
    chk("R6 no gap/err", {rdErr, gap}, 0);
    nextCycle();
    repeatLast = 2'b00;

    // R12 request from a channel not using the queue
    u = $urandom;
    push(u);
    chReq = 2'b10;
    @(negedge clk);
    chk("R12 no grant", chGrant, 0);
    nextCycle();
    chReq = 2'b00;
    @(negedge clk);
    chk("R12 word kept", empty, 0);
    chk("R12 ch1 untouched", ch1Data, 0);
    chk("R12 no flags", {rdErr, gap}, 0);
    nextCycle();

    // R10 clear
    doClear();
    @(negedge clk);
    chk("R10 cleared", empty, 1);
    nextCycle();

    // R4 / R5 shared interleave
    useFifo = 2'b11;
    for (int i = 0; i < 6; i++) begin
      s[i] = $urandom;
      push(s[i]);
    end
    chReq = 2'b10;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 ch1 waits", chGrant, 0);
      nextCycle();
    end
    chReq = 2'b00;
    for (int j = 0; j < 6; j++) begin
      chReq = 2'b11;
      @(negedge clk);
      chk("R4 alternation", chGrant, expGrant(j));
      nextCycle();
      chReq = 2'b00;
      @(negedge clk);
      if (j % 2 == 0) chk("R4 ch0 word", ch0Data, s[j]);
      else            chk("R4 ch1 word", ch1Data, s[j]);
      nextCycle();
    end

    // R7 repeat ignored while shared
    repeatLast = 2'b11;
    chReq = 2'b01;
    @(negedge clk);
    chk("R7 no grant", chGrant, 0);
    nextCycle();
    chReq = 2'b00;
    @(negedge clk);
    chk("R7 gap ch0", gap, 2'b01);
    chk("R7 data kept", ch0Data, s[4]);
    nextCycle();
    repeatLast = 2'b00;
    clrFlags(4'b1111);

    // R10 turn reset and same-cycle write dropped
    push($urandom);
    push($urandom);
    chReq = 2'b01;
    nextCycle();
    chReq = 2'b00;
    wrValid = 1'b1; wrData = 32'h1234_5678;
    clearFifo = 1'b1;
    nextCycle();
    wrValid = 1'b0; clearFifo = 1'b0;
    @(negedge clk);
    chk("R10 write dropped", empty, 1);
    nextCycle();
    u = $urandom;
    push(u);
    chReq = 2'b11;
    @(negedge clk);
    chk("R10 turn back to ch0", chGrant, 2'b01);
    nextCycle();
    chReq = 2'b00;
    @(negedge clk);
    chk("R10 ch0 word", ch0Data, u);
    nextCycle();

    // R2 random single-channel phase
    useFifo = 2'b01;
    doClear();
    clrFlags(4'b1111);
    lastExp = ch0Data;
    for (int n = 0; n < 400; n++) begin
      logic [1:0] g;
      int sz;
      wrValid = ($urandom % 3) != 0;
      wrData  = $urandom;
      chReq   = {1'b0, 1'(($urandom % 2))};
      sz = mq.size();
      @(negedge clk);
      g = (chReq[0] && sz > 0) ? 2'b01 : 2'b00;
      chk("R2 rnd data", ch0Data, lastExp);
      chk("R2 rnd grant", chGrant, g);
      chk("R2 rnd levels", {empty, full}, {sz == 0, sz == 8});
      nextCycle();
      if (g[0]) lastExp = mq.pop_front();
      if (wrValid && sz < 8) mq.push_back(wrData);
    end
    wrValid = 1'b0;
    chReq = 2'b00;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule